// File: doc/BRIEF.md
# Embedded Sync Code Decoder

This block sits on an 8-bit 4:2:2 component video word stream and pulls timing out of the data itself, with no separate sync wires. It searches for the four-word timing reference pattern (an all-ones word, two all-zeros words, then a status word). From the status word it recovers the field, vertical blanking and horizontal (start or end of active video) flags. Each complete code produces a one-cycle strobe that also tells whether the code opened or closed active video.

Between a start code and an end code, on lines that are not vertically blanked, the block steers the chroma/luma word sequence into pixel pairs. Each luma sample comes out together with the chroma sample that preceded it, and a flag says whether that chroma is the blue or the red difference. Each start code resets the chroma phase, so the first word after it is always taken as blue chroma. A word-valid strobe qualifies every word, and an enable input can freeze the block.

Top module: `refCodeDecoder`

## Requirements
- R1: A status word is recognised only when it directly follows an all-ones word (8'hFF) and then two all-zeros words (8'h00), counting only accepted words. On the clock edge that accepts the status word, `codeStrobe` pulses high for one cycle. `codeIsSav` is set to 1 when status bit 4 is 0 (start code) and to 0 when that bit is 1 (end code).
- R2: On each recognised code the status word sets the outputs: `fFlag` from bit 6, `vFlag` from bit 5 and `hFlag` from bit 4. Between codes the three flags hold their values.
- R3: Status bits 7 and 3 down to 0 have no effect on any output.
- R4: A preamble broken by any other word is abandoned without a strobe or a flag change. An all-ones word always starts a fresh preamble search, even in the middle of a preamble.
- R5: `activeVideo` becomes 1 on a start code whose bit 5 is 0. It becomes 0 on any end code and on a start code whose bit 5 is 1.
- R6: While `activeVideo` is 1, pixel words follow the order blue chroma, luma, red chroma, luma. After each luma word, `pairValid` pulses for one cycle. `pairY` then carries that luma and `pairC` the chroma word before it, and `pairIsCr` is 0 for blue chroma and 1 for red chroma.
- R7: A start code resets the chroma phase, so the next pixel word is taken as blue chroma even if a pair was left half-built.
- R8: Preamble words and the status word of a code never enter a pixel pair, including the words of an end code that arrives while `activeVideo` is 1. No pair is emitted on the cycle of a code strobe.
- R9: A word presented while `enable` or `wordValid` is 0 is ignored. It changes no flag, no preamble progress and no chroma phase, and it causes no strobe and no pair.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; 0 ignores all words |
| wordValid | input | 1 | Qualifies `wordIn` this cycle |
| wordIn | input | 8 | Video word stream |
| hFlag | output | 1 | Horizontal flag from the last code (1 = end of active video) |
| vFlag | output | 1 | Vertical blanking flag from the last code |
| fFlag | output | 1 | Field flag from the last code (1 = second field) |
| activeVideo | output | 1 | Pixel words are being steered |
| codeStrobe | output | 1 | One-cycle pulse per recognised code |
| codeIsSav | output | 1 | Last code was a start code |
| pairValid | output | 1 | One-cycle pulse with a new pixel pair |
| pairY | output | 8 | Luma of the pair |
| pairC | output | 8 | Chroma of the pair |
| pairIsCr | output | 1 | Pair chroma is red difference |

## Verification
Code decoding and pixel steering compete for the same words whenever an end code arrives while `activeVideo` is still 1. Its all-ones, all-zeros and status words would otherwise be taken as chroma and luma. The bench provokes this by sending the end code right after a completed pair, and again with a red chroma word left waiting. It then expects no `pairValid` on any of the four words, a single `codeStrobe` and `activeVideo` falling on the status word. A second collision, a start code cutting into a half-built pair, is judged by the chroma that appears in the next pair.

// File: rtl/refCodePkg.sv
package refCodePkg;
  // progress through the four-word reference pattern
  typedef enum logic [1:0] {
    SEEK_IDLE  = 2'd0,
    SEEK_ONES  = 2'd1,
    SEEK_ZERO1 = 2'd2,
    SEEK_ZERO2 = 2'd3
  } seekState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takePixel;   // current word is a pixel word
    logic phaseReset;  // restart at blue chroma
  } dpCtl_t;
endpackage

// File: rtl/refCodeCtrl.sv
module refCodeCtrl
  import refCodePkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordStrobe,
  input  logic [WORD_W-1:0] wordIn,
  output dpCtl_t            dpCtl,
  output logic              hFlag,
  output logic              vFlag,
  output logic              fFlag,
  output logic              activeVideo,
  output logic              codeStrobe,
  output logic              codeIsSav
);
  localparam int F_POS = WORD_W - 2;
  localparam int V_POS = WORD_W - 3;
  localparam int H_POS = WORD_W - 4;

  seekState_t seekState, seekNext;
  logic isOnes, isZero, isStatus;

  assign isOnes   = (wordIn == {WORD_W{1'b1}});
  assign isZero   = (wordIn == {WORD_W{1'b0}});
  assign isStatus = wordStrobe && (seekState == SEEK_ZERO2);

  always_comb begin
    seekNext = seekState;
    if (wordStrobe) begin
      unique case (seekState)
        SEEK_IDLE:  seekNext = isOnes ? SEEK_ONES : SEEK_IDLE;
        SEEK_ONES:  seekNext = isZero ? SEEK_ZERO1 : (isOnes ? SEEK_ONES : SEEK_IDLE);
        SEEK_ZERO1: seekNext = isZero ? SEEK_ZERO2 : (isOnes ? SEEK_ONES : SEEK_IDLE);
        SEEK_ZERO2: seekNext = SEEK_IDLE;
        default:    seekNext = SEEK_IDLE;
      endcase
    end
  end

  always_comb begin
    dpCtl.takePixel  = wordStrobe && activeVideo && !isStatus && !isOnes && !isZero;
    dpCtl.phaseReset = isStatus && !wordIn[H_POS];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seekState   <= SEEK_IDLE;
      hFlag       <= 1'b0;
      vFlag       <= 1'b0;
      fFlag       <= 1'b0;
      activeVideo <= 1'b0;
      codeStrobe  <= 1'b0;
      codeIsSav   <= 1'b0;
    end else begin
      seekState  <= seekNext;
      codeStrobe <= isStatus;
      if (isStatus) begin
        hFlag       <= wordIn[H_POS];
        vFlag       <= wordIn[V_POS];
        fFlag       <= wordIn[F_POS];
        codeIsSav   <= !wordIn[H_POS];
        activeVideo <= !wordIn[H_POS] && !wordIn[V_POS];
      end
    end
  end
endmodule

// File: rtl/refCodeData.sv
module refCodeData
  import refCodePkg::*;
#(
  parameter int WORD_W = 8,
  parameter int PHASES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [WORD_W-1:0] wordIn,
  output logic              pairValid,
  output logic [WORD_W-1:0] pairY,
  output logic [WORD_W-1:0] pairC,
  output logic              pairIsCr
);
  localparam int PH_W = $clog2(PHASES);

  logic [PH_W-1:0]   phase;
  logic [WORD_W-1:0] chromaHold;
  logic              lumaSlot;

  // odd phases carry luma, even phases carry chroma
  assign lumaSlot = phase[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= '0;
      chromaHold <= '0;
      pairValid  <= 1'b0;
      pairY      <= '0;
      pairC      <= '0;
      pairIsCr   <= 1'b0;
    end else begin
      pairValid <= dpCtl.takePixel && lumaSlot;
      if (dpCtl.phaseReset) begin
        phase <= '0;
      end else if (dpCtl.takePixel) begin
        phase <= phase + 1'b1;
        if (lumaSlot) begin
          pairY    <= wordIn;
          pairC    <= chromaHold;
          pairIsCr <= phase[PH_W-1];
        end else begin
          chromaHold <= wordIn;
        end
      end
    end
  end
endmodule

// File: rtl/refCodeDecoder.sv
module refCodeDecoder
  import refCodePkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordIn,
  output logic              hFlag,
  output logic              vFlag,
  output logic              fFlag,
  output logic              activeVideo,
  output logic              codeStrobe,
  output logic              codeIsSav,
  output logic              pairValid,
  output logic [WORD_W-1:0] pairY,
  output logic [WORD_W-1:0] pairC,
  output logic              pairIsCr
);
  dpCtl_t dpCtl;
  logic   wordStrobe;

  assign wordStrobe = enable && wordValid;

  refCodeCtrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wordStrobe(wordStrobe), .wordIn(wordIn),
    .dpCtl(dpCtl), .hFlag(hFlag), .vFlag(vFlag), .fFlag(fFlag),
    .activeVideo(activeVideo), .codeStrobe(codeStrobe), .codeIsSav(codeIsSav)
  );

  refCodeData #(.WORD_W(WORD_W)) u_data (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .wordIn(wordIn),
    .pairValid(pairValid), .pairY(pairY), .pairC(pairC), .pairIsCr(pairIsCr)
  );
endmodule

// File: rtl/refCodeChecker.sv
module refCodeChecker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic wordValid,
  input logic hFlag,
  input logic vFlag,
  input logic fFlag,
  input logic activeVideo,
  input logic codeStrobe,
  input logic codeIsSav,
  input logic pairValid
);
  // a code needs four words, so strobes never sit back to back
  assert_strobe_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    codeStrobe |=> !codeStrobe);

  assert_flags_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !codeStrobe |-> $stable({hFlag, vFlag, fFlag, activeVideo, codeIsSav}));

  assert_sav_h_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    codeStrobe |-> (codeIsSav == !hFlag));

  assert_active_not_blank_R5: assert property (@(posedge clk) disable iff (!rstN)
    activeVideo |-> (!vFlag && !hFlag));

  assert_pair_in_active_R6: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |-> activeVideo);

  assert_no_pair_on_code_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(pairValid && codeStrobe));

  assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(enable && wordValid) |=> (!pairValid && !codeStrobe));
endmodule

bind refCodeDecoder refCodeChecker u_refCodeChecker (
  .clk(clk), .rstN(rstN), .enable(enable), .wordValid(wordValid),
  .hFlag(hFlag), .vFlag(vFlag), .fFlag(fFlag), .activeVideo(activeVideo),
  .codeStrobe(codeStrobe), .codeIsSav(codeIsSav), .pairValid(pairValid)
);

// File: tb/test_refCodeDecoder.sv
module test_refCodeDecoder;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       wordValid = 1'b0;
  logic [7:0] wordIn = 8'h00;
  logic       hFlag, vFlag, fFlag, activeVideo, codeStrobe, codeIsSav;
  logic       pairValid, pairIsCr;
  logic [7:0] pairY, pairC;

  int errCount = 0;
  int chkCount = 0;
  bit finished = 1'b0;
  bit sawPair  = 1'b0;
  bit sawCode  = 1'b0;

  always #4 clk = ~clk;

  refCodeDecoder i_refCodeDecoder (
    .clk(clk), .rstN(rstN), .enable(enable), .wordValid(wordValid), .wordIn(wordIn),
    .hFlag(hFlag), .vFlag(vFlag), .fFlag(fFlag), .activeVideo(activeVideo),
    .codeStrobe(codeStrobe), .codeIsSav(codeIsSav), .pairValid(pairValid),
    .pairY(pairY), .pairC(pairC), .pairIsCr(pairIsCr)
  );

  // vector: word, pairValid, pairY, pairC, pairIsCr, {h, v, f, active, strobe}
  localparam int NV = 39;
  localparam logic [30:0] VEC [NV] = '{
    {8'hFF, 1'b0, 8'h00, 8'h00, 1'b0, 5'b00000},
    {8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 5'b00000},
    {8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 5'b00000},
    {8'h80, 1'b0, 8'h00, 8'h00, 1'b0, 5'b00011},
    {8'h10, 1'b0, 8'h00, 8'h00, 1'b0, 5'b00010},
    {8'h20, 1'b1, 8'h20, 8'h10, 1'b0, 5'b00010},
    {8'h30, 1'b0, 8'h00, 8'h00, 1'b0, 5'b00010},
    {8'h40, 1'b1, 8'h40, 8'h30, 1'b1, 5'b00010},
    {8'h50, 1'b0, 8'h00, 8'h00, 1'b0, 5'b00010},
    {8'h60, 1'b1, 8'h60, 8'h50, 1'b0, 5'b00010},
    {8'hFF, 1'b0, 8'h00, 8'h00, 1'b0, 5'b00010},
    {8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 5'b00010},
    {8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 5'b00010},
    {8'h9D, 1'b0, 8'h00, 8'h00, 1'b0, 5'b10001},
    {8'h80, 1'b0, 8'h00, 8'h00, 1'b0, 5'b10000},
    {8'h10, 1'b0, 8'h00, 8'h00, 1'b0, 5'b10000},
    {8'hFF, 1'b0, 8'h00, 8'h00, 1'b0, 5'b10000},
    {8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 5'b10000},
    {8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 5'b10000},
    {8'hEC, 1'b0, 8'h00, 8'h00, 1'b0, 5'b01101},
    {8'h80, 1'b0, 8'h00, 8'h00, 1'b0, 5'b01100},
    {8'h10, 1'b0, 8'h00, 8'h00, 1'b0, 5'b01100},
    {8'hFF, 1'b0, 8'h00, 8'h00, 1'b0, 5'b01100},
    {8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 5'b01100},
    {8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 5'b01100},
    {8'hF1, 1'b0, 8'h00, 8'h00, 1'b0, 5'b11101},
    {8'h80, 1'b0, 8'h00, 8'h00, 1'b0, 5'b11100},
    {8'hFF, 1'b0, 8'h00, 8'h00, 1'b0, 5'b11100},
    {8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 5'b11100},
    {8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 5'b11100},
    {8'hC7, 1'b0, 8'h00, 8'h00, 1'b0, 5'b00111},
    {8'hA1, 1'b0, 8'h00, 8'h00, 1'b0, 5'b00110},
    {8'hB2, 1'b1, 8'hB2, 8'hA1, 1'b0, 5'b00110},
    {8'hC3, 1'b0, 8'h00, 8'h00, 1'b0, 5'b00110},
    {8'hD4, 1'b1, 8'hD4, 8'hC3, 1'b1, 5'b00110},
    {8'hFF, 1'b0, 8'h00, 8'h00, 1'b0, 5'b00110},
    {8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 5'b00110},
    {8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 5'b00110},
    {8'h9D, 1'b0, 8'h00, 8'h00, 1'b0, 5'b10001}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    chkCount++;
    if (got !== exp) begin
      errCount++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // one word per two cycles; outputs sampled one edge after the word is taken
  task automatic sendWord(input logic [7:0] w);
    @(negedge clk);
    wordValid = 1'b1;
    wordIn    = w;
    @(negedge clk);
    wordValid = 1'b0;
    sawPair |= pairValid;
    sawCode |= codeStrobe;
  endtask

  task automatic sendCode(input logic [7:0] s);
    sendWord(8'hFF);
    sendWord(8'h00);
    sendWord(8'h00);
    sendWord(s);
  endtask

  function automatic logic [4:0] flagVec();
    return {hFlag, vFlag, fFlag, activeVideo, codeStrobe};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errCount++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errCount, chkCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 flags after reset", {27'd0, flagVec()}, 32'd0);
    chk("R10 pair after reset", {14'd0, pairValid, pairIsCr, pairY, pairC}, 32'd0);
    rstN   = 1'b1;
    enable = 1'b1;

    // table: R1 R2 R3 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      sendWord(VEC[i][30:23]);
      chk($sformatf("R1/R2/R5 flags vec %0d", i), {27'd0, flagVec()}, {27'd0, VEC[i][4:0]});
      chk($sformatf("R6/R8 pairValid vec %0d", i), {31'd0, pairValid}, {31'd0, VEC[i][22]});
      if (VEC[i][22])
        chk($sformatf("R6 pair data vec %0d", i), {15'd0, pairIsCr, pairY, pairC},
            {15'd0, VEC[i][5], VEC[i][21:14], VEC[i][13:6]});
    end

    // R3: only ignored bits set on a start code, blanking-level words 128/16
    sendCode(8'h8F);
    chk("R3 ignored bits start code", {27'd0, flagVec()}, {27'd0, 5'b00011});
    chk("R1 codeIsSav on start code", {31'd0, codeIsSav}, 32'd1);

    // R7: start code after a lone blue chroma word restarts the phase
    sendWord(8'h11);
    sendCode(8'h80);
    sendWord(8'h22);
    sendWord(8'h33);
    chk("R7 phase reset pair", {15'd0, pairIsCr, pairY, pairC}, {15'd0, 1'b0, 8'h33, 8'h22});

    // R8: end code with red chroma pending yields no pair
    sendWord(8'h44);
    sawPair = 1'b0;
    sendCode(8'h9D);
    chk("R8 end code words not pixels", {31'd0, sawPair}, 32'd0);
    chk("R8 end code decoded", {27'd0, flagVec()}, {27'd0, 5'b10001});
    chk("R1 codeIsSav on end code", {31'd0, codeIsSav}, 32'd0);

    // R4: broken preamble then a restart inside a preamble
    sawCode = 1'b0;
    sendWord(8'hFF); sendWord(8'h00); sendWord(8'h55); sendWord(8'h80);
    chk("R4 broken preamble no strobe", {31'd0, sawCode}, 32'd0);
    chk("R4 broken preamble flags held", {27'd0, flagVec()}, {27'd0, 5'b10000});
    sendWord(8'hFF); sendWord(8'hFF); sendWord(8'h00); sendWord(8'h00); sendWord(8'h80);
    chk("R4 restarted preamble decoded", {27'd0, flagVec()}, {27'd0, 5'b00011});

    // R9: words with enable low are ignored
    enable  = 1'b0;
    sawCode = 1'b0;
    sawPair = 1'b0;
    sendCode(8'h9D);
    sendWord(8'h10);
    sendWord(8'h20);
    chk("R9 disabled no strobe or pair", {30'd0, sawCode, sawPair}, 32'd0);
    chk("R9 disabled flags held", {27'd0, flagVec()}, {27'd0, 5'b00010});
    enable = 1'b1;
    sendWord(8'h5A);
    sendWord(8'h6B);
    chk("R9 phase untouched while disabled", {15'd0, pairIsCr, pairY, pairC},
        {15'd0, 1'b0, 8'h6B, 8'h5A});

    // R9: preamble progress is not advanced by invalid cycles
    @(negedge clk); wordIn = 8'hFF;
    @(negedge clk); wordIn = 8'h00;
    @(negedge clk);
    sawCode = 1'b0;
    sendWord(8'h00); sendWord(8'h00);
    chk("R9 invalid words no preamble", {31'd0, sawCode}, 32'd0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end
endmodule